// File: doc/BRIEF.md
# Three-Stage Gate Drive Sequencer

This block converts a single on/off command into the enable signals for the four switching paths of a power-transistor gate driver. The four paths are a strong pull-up, a controlled current source, a strong pull-down and a controlled current sink. Every rising and every falling edge of the command becomes its own three-stage sequence. Comparators that watch the device decide where each stage ends. Timers cover the boundaries that nothing senses, and they also act as watchdogs on the sensed boundaries.

On turn-on, the strong pull-up charges the gate quickly. It is released either a programmed lead time before a programmed stage-I length runs out, or, in threshold mode, when the gate-threshold comparator trips. The controlled source then limits the current slope until the current-peak comparator fires. After that the pull-up drives the gate to full bias. On turn-off, the strong pull-down runs until the desaturation comparator reports that collector voltage is rising. After a programmed extra delay, the controlled sink holds until the fall-end comparator fires. The pull-down then clamps the gate for the whole off state.

A soft-switching mode removes the controlled middle stage on both edges. The timing inputs are static settings, loaded when the block is initialised.

Top module: `gds_sequencer`

## Requirements
- R1: After reset the block is in the off state: pullDn=1, pullUp=srcEn=sinkEn=0, stage=3'b011, fault=0. The stage code is {direction (1=on), index}: index 0 is the dead cycle and 1..3 are stages I..III. The off state and the on state share index 3.
- R2: A new turn-on inserts exactly one dead cycle (stage=3'b100, all four outputs 0) before stage I (3'b101) starts with pullUp=1.
- R3: With cfgThreshMode=0, turn-on stage I lasts cfgS1Len cycles. pullUp is 1 only in the first cfgS1Len-cfgLead of those cycles and 0 in the rest.
- R4: With cfgThreshMode=1, stage I holds pullUp=1 until the cycle after gateAboveVth is seen high, however long that takes.
- R5: Turn-on stage II (3'b110) enables only srcEn and lasts until icPeak is seen. Stage III (3'b111) then holds pullUp=1 for as long as the device stays on.
- R6: A low cmdOn is acted on only once the on sequence has lasted cfgMinOn cycles, counted from the first stage-I cycle.
- R7: Turn-off passes one dead cycle (3'b000). Stage I (3'b001, pullDn) continues until desatRise, then for cfgOffDelay more cycles. Stage II (3'b010, sinkEn only) lasts until icFallEnd. Stage III (3'b011, pullDn) holds.
- R8: The outputs pullUp/srcEn are never 1 while the direction bit is 0. Pull-side and push-side outputs are never 1 in the same cycle, and never in adjacent cycles.
- R9: With cfgSoftMode=1, both edges go from stage I directly to stage III, and srcEn/sinkEn stay 0.
- R10: If an event-driven stage does not see its comparator within cfgTimeout cycles, the sequencer enters stage III and sets fault. fault stays set until reset.
- R11: A high cmdOn during any turn-off stage abandons that sequence and goes through the turn-on dead cycle to turn-on stage I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdOn | input | 1 | Switching command, 1 = device on |
| gateAboveVth | input | 1 | Gate voltage above threshold comparator |
| icPeak | input | 1 | Collector current at load plus recovery peak |
| desatRise | input | 1 | Collector voltage starting to rise |
| icFallEnd | input | 1 | End of fast collector current fall |
| cfgThreshMode | input | 1 | 1 = end turn-on stage I on threshold comparator |
| cfgSoftMode | input | 1 | 1 = skip stage II on both edges |
| cfgS1Len | input | CW | Timed turn-on stage I length in cycles |
| cfgLead | input | CW | Early pull-up release before end of timed stage I |
| cfgMinOn | input | CW | Minimum on-sequence length in cycles |
| cfgOffDelay | input | CW | Extra stage-I cycles after desaturation on turn-off |
| cfgTimeout | input | CW | Limit for event-driven stages in cycles |
| pullUp | output | 1 | Strong pull-up enable |
| srcEn | output | 1 | Controlled source enable |
| pullDn | output | 1 | Strong pull-down enable |
| sinkEn | output | 1 | Controlled sink enable |
| stage | output | 3 | Stage code {direction, index} |
| fault | output | 1 | Sticky comparator timeout flag |

## Verification
Properties check on every cycle that the two drive directions are never enabled together, that one empty cycle always separates them, and that nothing on the source side is enabled while turning off. They also check that at most one path is active at a time, that dead cycles are quiet, and that the fault flag stays set once raised. The bench scenarios are needed for the cycle-exact stage lengths: the early pull-up release, the minimum on time, the post-desaturation delay and the timeout count. They also cover the mode bits and command reversals, because each of these depends on programmed values and on comparator timing.

// File: rtl/gds_pkg.sv
package gds_pkg;

  typedef enum logic [3:0] {
    ST_OFF_DEAD, ST_OFF_S1, ST_OFF_WAIT, ST_OFF_S2, ST_OFF_S3,
    ST_ON_DEAD,  ST_ON_S1,  ST_ON_S2,    ST_ON_S3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrStage;
    logic clrAge;
    logic setFault;
  } seqStrobe_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic s1Done;
    logic puRelease;
    logic timedOut;
    logic dlyDone;
    logic dlyZero;
    logic minOnMet;
  } seqFlags_t;

endpackage

// File: rtl/gds_timer.sv
module gds_timer
  import gds_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strobe,
  input  logic [CW-1:0] cfgS1Len,
  input  logic [CW-1:0] cfgLead,
  input  logic [CW-1:0] cfgMinOn,
  input  logic [CW-1:0] cfgOffDelay,
  input  logic [CW-1:0] cfgTimeout,
  output seqFlags_t     flags,
  output logic          fault
);
  localparam int XW = CW + 1;
  localparam logic [XW-1:0] ONE = XW'(1);

  logic [CW-1:0] stageCnt, onAge;
  logic [XW-1:0] cntX, ageX;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageCnt <= '0;
      onAge    <= '0;
      fault    <= 1'b0;
    end else begin
      if (strobe.clrStage)      stageCnt <= '0;
      else if (stageCnt != '1)  stageCnt <= stageCnt + 1'b1;
      if (strobe.clrAge)        onAge <= '0;
      else if (onAge != '1)     onAge <= onAge + 1'b1;
      if (strobe.setFault)      fault <= 1'b1;
    end
  end

  assign cntX = {1'b0, stageCnt};
  assign ageX = {1'b0, onAge};

  // a stage of length N ends in the cycle where count+1 reaches N
  assign flags.s1Done    = (cntX + ONE) >= {1'b0, cfgS1Len};
  assign flags.puRelease = (cntX + {1'b0, cfgLead}) >= {1'b0, cfgS1Len};
  assign flags.timedOut  = (cntX + ONE) >= {1'b0, cfgTimeout};
  assign flags.dlyDone   = (cntX + ONE) >= {1'b0, cfgOffDelay};
  assign flags.dlyZero   = (cfgOffDelay == '0);
  assign flags.minOnMet  = (ageX + ONE) >= {1'b0, cfgMinOn};

endmodule

// File: rtl/gds_fsm.sv
module gds_fsm
  import gds_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdOn,
  input  logic       gateAboveVth,
  input  logic       icPeak,
  input  logic       desatRise,
  input  logic       icFallEnd,
  input  logic       cfgThreshMode,
  input  logic       cfgSoftMode,
  input  seqFlags_t  flags,
  output seqStrobe_t strobe,
  output logic       pullUp,
  output logic       srcEn,
  output logic       pullDn,
  output logic       sinkEn,
  output logic [2:0] stage
);
  seqState_t state, nextState;
  logic faultNow;
  logic onS1Exit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF_S3;
    else       state <= nextState;
  end

  assign onS1Exit = cfgThreshMode ? gateAboveVth : flags.s1Done;

  always_comb begin
    nextState = state;
    faultNow  = 1'b0;
    unique case (state)
      ST_OFF_DEAD: nextState = ST_OFF_S1;
      ST_ON_DEAD:  nextState = ST_ON_S1;
      ST_OFF_S1: begin
        if (cmdOn) nextState = ST_ON_DEAD;
        else if (desatRise) begin
          if (cfgSoftMode)        nextState = ST_OFF_S3;
          else if (flags.dlyZero) nextState = ST_OFF_S2;
          else                    nextState = ST_OFF_WAIT;
        end else if (flags.timedOut) begin
          nextState = ST_OFF_S3;
          faultNow  = 1'b1;
        end
      end
      ST_OFF_WAIT: begin
        if (cmdOn)              nextState = ST_ON_DEAD;
        else if (flags.dlyDone) nextState = ST_OFF_S2;
      end
      ST_OFF_S2: begin
        if (cmdOn)          nextState = ST_ON_DEAD;
        else if (icFallEnd) nextState = ST_OFF_S3;
        else if (flags.timedOut) begin
          nextState = ST_OFF_S3;
          faultNow  = 1'b1;
        end
      end
      ST_OFF_S3: if (cmdOn) nextState = ST_ON_DEAD;
      ST_ON_S1, ST_ON_S2, ST_ON_S3: begin
        if (!cmdOn && flags.minOnMet) nextState = ST_OFF_DEAD;
        else if (state == ST_ON_S1) begin
          if (onS1Exit) nextState = cfgSoftMode ? ST_ON_S3 : ST_ON_S2;
          else if (cfgThreshMode && flags.timedOut) begin
            nextState = ST_ON_S3;
            faultNow  = 1'b1;
          end
        end else if (state == ST_ON_S2) begin
          if (icPeak) nextState = ST_ON_S3;
          else if (flags.timedOut) begin
            nextState = ST_ON_S3;
            faultNow  = 1'b1;
          end
        end
      end
      default: nextState = ST_OFF_S3;
    endcase
  end

  assign strobe.clrStage = (nextState != state);
  assign strobe.clrAge   = (nextState == ST_ON_S1) && (state != ST_ON_S1);
  assign strobe.setFault = faultNow;

  always_comb begin
    pullUp = ((state == ST_ON_S1) && (cfgThreshMode || !flags.puRelease))
             || (state == ST_ON_S3);
    srcEn  = (state == ST_ON_S2);
    pullDn = (state == ST_OFF_S1) || (state == ST_OFF_WAIT) || (state == ST_OFF_S3);
    sinkEn = (state == ST_OFF_S2);
    unique case (state)
      ST_OFF_DEAD:            stage = 3'b000;
      ST_OFF_S1, ST_OFF_WAIT: stage = 3'b001;
      ST_OFF_S2:              stage = 3'b010;
      ST_OFF_S3:              stage = 3'b011;
      ST_ON_DEAD:             stage = 3'b100;
      ST_ON_S1:               stage = 3'b101;
      ST_ON_S2:               stage = 3'b110;
      ST_ON_S3:               stage = 3'b111;
      default:                stage = 3'b011;
    endcase
  end

endmodule

// File: rtl/gds_sequencer.sv
module gds_sequencer
  import gds_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdOn,
  input  logic          gateAboveVth,
  input  logic          icPeak,
  input  logic          desatRise,
  input  logic          icFallEnd,
  input  logic          cfgThreshMode,
  input  logic          cfgSoftMode,
  input  logic [CW-1:0] cfgS1Len,
  input  logic [CW-1:0] cfgLead,
  input  logic [CW-1:0] cfgMinOn,
  input  logic [CW-1:0] cfgOffDelay,
  input  logic [CW-1:0] cfgTimeout,
  output logic          pullUp,
  output logic          srcEn,
  output logic          pullDn,
  output logic          sinkEn,
  output logic [2:0]    stage,
  output logic          fault
);
  seqStrobe_t strobe;
  seqFlags_t  flags;

  gds_fsm i_fsm (
    .clk, .rstN, .cmdOn, .gateAboveVth, .icPeak, .desatRise, .icFallEnd,
    .cfgThreshMode, .cfgSoftMode, .flags, .strobe,
    .pullUp, .srcEn, .pullDn, .sinkEn, .stage
  );

  gds_timer #(.CW(CW)) i_timer (
    .clk, .rstN, .strobe, .cfgS1Len, .cfgLead, .cfgMinOn,
    .cfgOffDelay, .cfgTimeout, .flags, .fault
  );

endmodule

// File: rtl/gds_checker.sv
module gds_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pullUp,
  input logic       srcEn,
  input logic       pullDn,
  input logic       sinkEn,
  input logic [2:0] stage,
  input logic       fault
);
  logic pushSide, pullSide;
  assign pushSide = pullUp || srcEn;
  assign pullSide = pullDn || sinkEn;

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(pushSide && pullSide));

  a_r8_dead_up_to_dn: assert property (@(posedge clk) disable iff (!rstN)
    pushSide |=> !pullSide);

  a_r8_dead_dn_to_up: assert property (@(posedge clk) disable iff (!rstN)
    pullSide |=> !pushSide);

  a_r8_no_source_off: assert property (@(posedge clk) disable iff (!rstN)
    !stage[2] |-> !pushSide);

  a_r5_single_path: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pullUp, srcEn, pullDn, sinkEn}));

  a_r2_dead_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stage[1:0] == 2'b00) |-> !(pushSide || pullSide));

  a_r7_off_clamp: assert property (@(posedge clk) disable iff (!rstN)
    (stage == 3'b011) |-> pullDn);

  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> fault);

endmodule

bind gds_sequencer gds_checker i_chk (
  .clk(clk), .rstN(rstN), .pullUp(pullUp), .srcEn(srcEn),
  .pullDn(pullDn), .sinkEn(sinkEn), .stage(stage), .fault(fault)
);

// File: tb/test_gds_sequencer.sv
module test_gds_sequencer;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdOn = 0, gateAboveVth = 0, icPeak = 0, desatRise = 0, icFallEnd = 0;
  logic cfgThreshMode = 0, cfgSoftMode = 0;
  logic [CW-1:0] cfgS1Len = 8'd3, cfgLead = 8'd1, cfgMinOn = 8'd12;
  logic [CW-1:0] cfgOffDelay = 8'd2, cfgTimeout = 8'd20;
  logic pullUp, srcEn, pullDn, sinkEn, fault;
  logic [2:0] stage;

  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  gds_sequencer #(.CW(CW)) i_gds_sequencer (
    .clk, .rstN, .cmdOn, .gateAboveVth, .icPeak, .desatRise, .icFallEnd,
    .cfgThreshMode, .cfgSoftMode, .cfgS1Len, .cfgLead, .cfgMinOn,
    .cfgOffDelay, .cfgTimeout, .pullUp, .srcEn, .pullDn, .sinkEn,
    .stage, .fault
  );

  // row: [11:7] inputs {cmd,gate,peak,desat,fall}, [6:0] expected {pu,src,pd,snk,stage}
  localparam int NV = 21;
  localparam logic [11:0] VEC [NV] = '{
    {5'b10000, 7'b0010_011},
    {5'b10000, 7'b0000_100},
    {5'b10000, 7'b1000_101},
    {5'b10000, 7'b1000_101},
    {5'b10000, 7'b0000_101},
    {5'b10100, 7'b0100_110},
    {5'b00000, 7'b1000_111},
    {5'b00000, 7'b1000_111},
    {5'b00000, 7'b1000_111},
    {5'b00000, 7'b1000_111},
    {5'b00000, 7'b1000_111},
    {5'b00000, 7'b1000_111},
    {5'b00000, 7'b1000_111},
    {5'b00000, 7'b1000_111},
    {5'b00000, 7'b0000_000},
    {5'b00010, 7'b0010_001},
    {5'b00000, 7'b0010_001},
    {5'b00000, 7'b0010_001},
    {5'b00001, 7'b0001_010},
    {5'b00000, 7'b0010_011},
    {5'b00000, 7'b0010_011}
  };

  function automatic string reqOf(int i);
    if (i <= 1)  return "R2";
    if (i <= 4)  return "R3";
    if (i <= 6)  return "R5";
    if (i <= 13) return "R6";
    return "R7";
  endfunction

  function automatic logic [6:0] obs();
    return {pullUp, srcEn, pullDn, sinkEn, stage};
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic setIn(logic [4:0] v);
    {cmdOn, gateAboveVth, icPeak, desatRise, icFallEnd} = v;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    setIn(5'b0);
    step(2);
    rstN = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    nBad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    // R1 reset state
    step(1);
    doReset();
    chk("R1 outputs", {1'b0, obs()}, {1'b0, 7'b0010_011});
    chk("R1 fault", {7'b0, fault}, 8'd0);

    // table: timed stage I, full on/off with minimum on time
    for (int i = 0; i < NV; i++) begin
      chk(reqOf(i), {1'b0, obs()}, {1'b0, VEC[i][6:0]});
      setIn(VEC[i][11:7]);
      step(1);
    end

    // R4 / R9: threshold mode with soft switching
    cfgThreshMode = 1; cfgSoftMode = 1; cfgMinOn = 8'd1; cfgTimeout = 8'd50;
    doReset();
    cmdOn = 1;
    step(2);
    step(5);
    chk("R4 pull-up held past timed length", {1'b0, obs()}, {1'b0, 7'b1000_101});
    gateAboveVth = 1;
    step(1);
    chk("R9 on skips stage II", {1'b0, obs()}, {1'b0, 7'b1000_111});
    gateAboveVth = 0; cmdOn = 0;
    step(2);
    chk("R9 off stage I", {1'b0, obs()}, {1'b0, 7'b0010_001});
    desatRise = 1;
    step(1);
    chk("R9 off skips stage II", {1'b0, obs()}, {1'b0, 7'b0010_011});
    desatRise = 0;

    // R10: timeout in turn-on stage II
    cfgThreshMode = 0; cfgSoftMode = 0; cfgTimeout = 8'd4;
    doReset();
    cmdOn = 1;
    step(5);
    chk("R10 stage II no fault yet", {fault, obs()}, {1'b0, 7'b0100_110});
    step(3);
    chk("R10 last stage II cycle", {fault, obs()}, {1'b0, 7'b0100_110});
    step(1);
    chk("R10 timeout to stage III", {fault, obs()}, {1'b1, 7'b1000_111});
    cmdOn = 0; desatRise = 1; icFallEnd = 1;
    step(10);
    chk("R10 fault sticky in off state", {fault, obs()}, {1'b1, 7'b0010_011});
    rstN = 1'b0;
    step(1);
    chk("R1 reset clears fault", {fault, obs()}, {1'b0, 7'b0010_011});
    rstN = 1'b1;
    setIn(5'b0);

    // R11 / R8: reversal during turn-off stage II
    cfgTimeout = 8'd50;
    step(1);
    cmdOn = 1; icPeak = 1;
    step(8);
    chk("R5 on held", {1'b0, obs()}, {1'b0, 7'b1000_111});
    cmdOn = 0; icPeak = 0; desatRise = 1;
    step(1);
    chk("R8 dead before pull-down", {1'b0, obs()}, {1'b0, 7'b0000_000});
    step(1);
    chk("R8 turn-off stage I no source", {1'b0, obs()}, {1'b0, 7'b0010_001});
    step(3);
    chk("R8 turn-off stage II sink only", {1'b0, obs()}, {1'b0, 7'b0001_010});
    cmdOn = 1; desatRise = 0;
    step(1);
    chk("R11 abort to on dead cycle", {1'b0, obs()}, {1'b0, 7'b0000_100});
    step(1);
    chk("R11 turn-on stage I", {1'b0, obs()}, {1'b0, 7'b1000_101});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule